// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a 32-bit physical address by walking a two-level table held in memory. A client hands it an address through a valid/ready request port. The walker reads one word from a 4096-entry directory. If that entry is usable, it reads one more word from a 256-entry leaf table. It then returns either the physical address with the 4-bit access-class index of the page, or a fault that names the level that failed.

The split is fixed: address bits 31:20 pick the directory slot, bits 19:12 pick the leaf slot, and bits 11:0 pass straight through as the offset within a 4 KB page. Every entry is one 32-bit word. A directory entry counts as usable only when its two low bits read exactly 01. A leaf entry has a single valid flag in bit 1 and carries its access-class index in bits 7:4. The directory base comes from a register loaded over a small write port. Memory is reached through a word-read port that keeps at most one read in flight.

Top module: `iova_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to directory base + (iova[31:20] × 4). The base used is the value held when the request was accepted.
- R3: A directory word is accepted only when its bits 1:0 equal 01. Codes 00, 10 and 11 end the walk after exactly one read, with `rsp_fault`=1 and `rsp_fault_level`=0.
- R4: After a usable directory word, the second read goes to {dte[31:10], 10'b0} + (iova[19:12] × 4). Directory bits 9:2 have no effect on that address.
- R5: A leaf word with bit 1 clear ends the walk after two reads, with `rsp_fault`=1, `rsp_fault_level`=1, `rsp_paddr`=0 and `rsp_aci`=0. No fault response ever carries a nonzero `rsp_paddr` or `rsp_aci`.
- R6: A leaf word with bit 1 set gives `rsp_fault`=0, `rsp_paddr`={pte[31:12], iova[11:0]} and `rsp_aci`=pte[7:4].
- R7: Every response, faulting or not, returns the accepted virtual address on `rsp_iova`.
- R8: A raised `mem_req_valid` stays raised with a stable `mem_req_addr` until `mem_req_ready`. No new read is issued before the previous read's data has returned.
- R9: `req_ready` stays 0 from acceptance until the response is taken. A response stays valid and unchanged while `rsp_ready` is 0.
- R10: A base-register write made while a walk is in progress affects only walks accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Load the directory base register |
| base_wr_data | input | 32 | New directory base (word aligned) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_iova | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Walk failed |
| rsp_fault_level | output | 1 | 0 = directory level, 1 = leaf level |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_aci | output | 4 | Access-class index of the page (0 on fault) |
| rsp_iova | output | 32 | Virtual address of this result |

## Verification
The assertions assume that memory raises `mem_rsp_valid` for exactly one cycle per accepted read, and only while that read is outstanding. They also assume that the client holds its request stable while waiting. The bench memory model answers each accepted read one cycle after the handshake and never responds without being asked. It can throttle `mem_req_ready` in a one-in-three pattern, and the client tasks change inputs only on falling edges. Under that stimulus the hold and single-outstanding properties are exercised with real backpressure on both the memory and the response side.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W          = 32;
  localparam int LEAF_IDX_W    = 8;
  localparam int PG_OFF_W      = 12;
  localparam int DOM_W         = 4;
  localparam int DOM_LSB       = 4;
  localparam int ENTRY_SHIFT   = 2;
  localparam int LEAF_OK_POS   = 1;
  localparam logic [1:0] DIR_OK_CODE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_LEAF = 2'd2,
    ST_RESP = 2'd3
  } walk_state_t;
endpackage

// File: rtl/walk_entry_dec.sv
module walk_entry_dec
  import walk_pkg::*;
#(
  parameter int ADDR_W     = VA_W,
  parameter int LEAF_IDX_W_P = LEAF_IDX_W,
  parameter int PG_OFF_W_P = PG_OFF_W,
  parameter int DOM_W_P    = DOM_W
) (
  input  logic [ADDR_W-1:0]            word,
  output logic                         dir_ok,
  output logic [ADDR_W-1:0]            tbl_base,
  output logic                         leaf_ok,
  output logic [ADDR_W-PG_OFF_W_P-1:0] frame,
  output logic [DOM_W_P-1:0]           dom
);
  localparam int TBL_ALIGN = LEAF_IDX_W_P + ENTRY_SHIFT;

  // Directory format: table pointer above the leaf-table alignment, 2-bit type code at the bottom.
  always_comb begin
    dir_ok   = (word[1:0] == DIR_OK_CODE);
    tbl_base = {word[ADDR_W-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};
  end

  // Leaf format: page frame above the offset, access-class field, single valid flag.
  always_comb begin
    leaf_ok = word[LEAF_OK_POS];
    frame   = word[ADDR_W-1:PG_OFF_W_P];
    dom     = word[DOM_LSB +: DOM_W_P];
  end
endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
  import walk_pkg::*;
#(
  parameter int ADDR_W       = VA_W,
  parameter int DIR_IDX_W    = 12,
  parameter int LEAF_IDX_W_P = LEAF_IDX_W
) (
  input  logic [ADDR_W-1:0]       dir_base,
  input  logic [DIR_IDX_W-1:0]    dir_idx,
  input  logic [ADDR_W-1:0]       tbl_base,
  input  logic [LEAF_IDX_W_P-1:0] leaf_idx,
  output logic [ADDR_W-1:0]       dir_addr,
  output logic [ADDR_W-1:0]       leaf_addr
);
  always_comb begin
    dir_addr  = dir_base + (ADDR_W'(dir_idx)  << ENTRY_SHIFT);
    leaf_addr = tbl_base + (ADDR_W'(leaf_idx) << ENTRY_SHIFT);
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int ADDR_W   = VA_W,
  parameter int PG_OFF_W_P = PG_OFF_W,
  parameter int DOM_W_P  = DOM_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_iova,
  output logic [ADDR_W-1:0]            held_iova,
  input  logic [ADDR_W-1:0]            dir_addr,
  input  logic [ADDR_W-1:0]            leaf_addr,
  input  logic                         dir_ok,
  input  logic                         leaf_ok,
  input  logic [ADDR_W-PG_OFF_W_P-1:0] frame,
  input  logic [DOM_W_P-1:0]           dom,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [ADDR_W-1:0]            mem_req_addr,
  input  logic                         mem_rsp_valid,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic                         rsp_fault,
  output logic                         rsp_fault_level,
  output logic [ADDR_W-1:0]            rsp_paddr,
  output logic [DOM_W_P-1:0]           rsp_aci
);
  walk_state_t       state_q, state_d;
  logic              sent_q, sent_d;
  logic [ADDR_W-1:0] va_q, addr_q, addr_d, pa_q, pa_d;
  logic [DOM_W_P-1:0] dom_q, dom_d;
  logic              flt_q, flt_d, lvl_q, lvl_d;
  logic              va_en, addr_en, res_en;
  logic              walking, data_in;

  assign walking = (state_q == ST_DIR) || (state_q == ST_LEAF);
  assign data_in = walking && sent_q && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    sent_d  = sent_q;
    addr_d  = addr_q;
    pa_d    = '0;
    dom_d   = '0;
    flt_d   = 1'b0;
    lvl_d   = 1'b0;
    va_en   = 1'b0;
    addr_en = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_en   = 1'b1;
          addr_en = 1'b1;
          addr_d  = dir_addr;
          sent_d  = 1'b0;
          state_d = ST_DIR;
        end
      end
      ST_DIR, ST_LEAF: begin
        if (!sent_q && mem_req_ready) sent_d = 1'b1;
        if (data_in) begin
          sent_d = 1'b0;
          if (state_q == ST_DIR) begin
            if (dir_ok) begin
              addr_en = 1'b1;
              addr_d  = leaf_addr;
              state_d = ST_LEAF;
            end else begin
              res_en  = 1'b1;
              flt_d   = 1'b1;
              lvl_d   = 1'b0;
              state_d = ST_RESP;
            end
          end else begin
            res_en  = 1'b1;
            state_d = ST_RESP;
            if (leaf_ok) begin
              pa_d  = {frame, va_q[PG_OFF_W_P-1:0]};
              dom_d = dom;
            end else begin
              flt_d = 1'b1;
              lvl_d = 1'b1;
            end
          end
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sent_q  <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va_q <= '0;
    else if (va_en) va_q <= req_iova;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      dom_q <= '0;
      flt_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (res_en) begin
      pa_q  <= pa_d;
      dom_q <= dom_d;
      flt_q <= flt_d;
      lvl_q <= lvl_d;
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign held_iova       = va_q;
  assign mem_req_valid   = walking && !sent_q;
  assign mem_req_addr    = addr_q;
  assign rsp_valid       = (state_q == ST_RESP);
  assign rsp_fault       = flt_q;
  assign rsp_fault_level = lvl_q;
  assign rsp_paddr       = pa_q;
  assign rsp_aci         = dom_q;

  // A read held back by memory keeps its address.
  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // Once a read is accepted, no further read until its data returns.
  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // A pending result is held unchanged.
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
      && $stable(rsp_fault_level) && $stable(rsp_aci));

  // No new request accepted while a result waits.
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // Faults carry no translation.
  assert_fault_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_paddr == '0) && (rsp_aci == '0));

  // Page offset passes through on success.
  assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[PG_OFF_W_P-1:0] == va_q[PG_OFF_W_P-1:0]);
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W     = VA_W,
  parameter int LEAF_IDX_W_P = LEAF_IDX_W,
  parameter int PG_OFF_W_P = PG_OFF_W,
  parameter int DOM_W_P    = DOM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_en,
  input  logic [31:0]       base_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_iova,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic              rsp_fault_level,
  output logic [31:0]       rsp_paddr,
  output logic [3:0]        rsp_aci,
  output logic [31:0]       rsp_iova
);
  localparam int DIR_IDX_W = ADDR_W - LEAF_IDX_W_P - PG_OFF_W_P;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_W-1:0] dir_base_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      dir_base_q <= '0;
    else if (base_wr_en) dir_base_q <= base_wr_data;
  end

  logic [ADDR_W-1:0]            held_iova, dir_addr, leaf_addr, tbl_base;
  logic                         dir_ok, leaf_ok;
  logic [ADDR_W-PG_OFF_W_P-1:0] frame;
  logic [DOM_W_P-1:0]           dom;

  walk_entry_dec #(
    .ADDR_W(ADDR_W), .LEAF_IDX_W_P(LEAF_IDX_W_P),
    .PG_OFF_W_P(PG_OFF_W_P), .DOM_W_P(DOM_W_P)
  ) u_dec (
    .word(mem_rsp_data), .dir_ok(dir_ok), .tbl_base(tbl_base),
    .leaf_ok(leaf_ok), .frame(frame), .dom(dom)
  );

  walk_addr_gen #(
    .ADDR_W(ADDR_W), .DIR_IDX_W(DIR_IDX_W), .LEAF_IDX_W_P(LEAF_IDX_W_P)
  ) u_agen (
    .dir_base(dir_base_q),
    .dir_idx(req_iova[ADDR_W-1 -: DIR_IDX_W]),
    .tbl_base(tbl_base),
    .leaf_idx(held_iova[PG_OFF_W_P +: LEAF_IDX_W_P]),
    .dir_addr(dir_addr),
    .leaf_addr(leaf_addr)
  );

  walk_ctrl #(
    .ADDR_W(ADDR_W), .PG_OFF_W_P(PG_OFF_W_P), .DOM_W_P(DOM_W_P)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
    .held_iova(held_iova),
    .dir_addr(dir_addr), .leaf_addr(leaf_addr),
    .dir_ok(dir_ok), .leaf_ok(leaf_ok), .frame(frame), .dom(dom),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
    .rsp_paddr(rsp_paddr), .rsp_aci(rsp_aci)
  );

  assign rsp_iova = held_iova;

  // Result address echoes the accepted request.
  assert_iova_echo_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid && !rsp_ready |=> $stable(rsp_iova));
endmodule

// File: tb/iova_walker_bench.sv
module iova_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_iova;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_fault;
  logic        rsp_fault_level;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_aci;
  logic [31:0] rsp_iova;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  iova_walker u_iova_walker (.*);

  // Memory model
  logic [31:0] mem [logic [31:0]];
  bit          stall_mode = 0;
  bit          pend = 0;
  logic [31:0] pend_addr;
  int          nreads = 0;
  logic [31:0] rd_log [0:3];
  bit          was_wait = 0;
  logic [31:0] wait_addr;
  bit          stab_err = 0;
  bit          ovl_err = 0;
  int          cyc = 0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  initial begin
    mem_rsp_valid = 0;
    mem_rsp_data  = 0;
    mem_req_ready = 1;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 0;
      if (pend) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mem_rd(pend_addr);
        pend = 0;
      end
      if (was_wait && (!mem_req_valid || mem_req_addr != wait_addr)) stab_err = 1;
      if (mem_req_valid && mem_rsp_valid) ovl_err = 1;
      mem_req_ready = stall_mode ? (cyc % 3 == 2) : 1'b1;
      was_wait = mem_req_valid && !mem_req_ready;
      wait_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1;
        pend_addr = mem_req_addr;
        if (nreads < 4) rd_log[nreads] = mem_req_addr;
        nreads++;
      end
    end
  end

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 0;
  endtask

  task automatic walk(input string rq, input logic [31:0] va,
                      input bit e_flt, input bit e_lvl,
                      input logic [31:0] e_pa, input logic [3:0] e_aci,
                      input int e_reads, input logic [31:0] e_a0, input logic [31:0] e_a1,
                      input bit wr_base, input logic [31:0] nbase);
    int waited;
    @(negedge clk);
    nreads = 0; stab_err = 0; ovl_err = 0;
    check("R9", "req_ready idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1; req_iova = va;
    @(negedge clk);
    req_valid = 0; req_iova = 32'hDEAD_BEEF;
    if (wr_base) begin base_wr_en = 1; base_wr_data = nbase; end
    check("R9", "req_ready busy", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    base_wr_en = 0;
    waited = 0;
    while (!rsp_valid && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check(rq, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(rq, "fault", {31'b0, rsp_fault}, {31'b0, e_flt});
    if (e_flt) check(rq, "fault level", {31'b0, rsp_fault_level}, {31'b0, e_lvl});
    check(rq, "paddr", rsp_paddr, e_pa);
    check(rq, "aci", {28'b0, rsp_aci}, {28'b0, e_aci});
    check("R7", "iova echo", rsp_iova, va);
    check(rq, "read count", nreads, e_reads);
    check("R2", "first read addr", rd_log[0], e_a0);
    if (e_reads > 1) check("R4", "second read addr", rd_log[1], e_a1);
    check("R8", "read hold / overlap", {30'b0, stab_err, ovl_err}, 32'd0);
    // hold the result for a few cycles
    repeat (3) @(negedge clk);
    check("R9", "rsp held", {31'b0, rsp_valid}, 32'd1);
    check("R9", "paddr held", rsp_paddr, e_pa);
    check("R9", "req_ready while rsp", {31'b0, req_ready}, 32'd0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check("R9", "rsp dropped", {31'b0, rsp_valid}, 32'd0);
    check("R9", "idle again", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    check("R1", "req_ready", {31'b0, req_ready}, 32'd1);
    check("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_success;
    // dte bits 9:2 set to junk; must not shift the leaf address (R4)
    mem[32'h0010_048C] = 32'h0020_04FD;
    mem[32'h0020_0514] = 32'hABCD_E0A2;
    walk("R6", 32'h1234_5678, 0, 0, 32'hABCD_E678, 4'hA, 2,
         32'h0010_048C, 32'h0020_0514, 0, 0);
  endtask

  task automatic t_dir_codes;
    logic [1:0] codes [0:2];
    codes[0] = 2'b00; codes[1] = 2'b10; codes[2] = 2'b11;
    for (int i = 0; i < 3; i++) begin
      mem[32'h0010_0004] = 32'h0030_0400 | {30'b0, codes[i]};
      walk("R3", 32'h0010_0ABC, 1, 0, 32'h0, 4'h0, 1, 32'h0010_0004, 32'h0, 0, 0);
    end
  endtask

  task automatic t_leaf_fault;
    mem[32'h0010_0008] = 32'h0060_0001;
    mem[32'h0060_03FC] = 32'hFFFF_FFFD;
    walk("R5", 32'h002F_F123, 1, 1, 32'h0, 4'h0, 2, 32'h0010_0008, 32'h0060_03FC, 0, 0);
  endtask

  task automatic t_stall_edge;
    stall_mode = 1;
    mem[32'h0010_3FFC] = 32'h0040_0001;
    mem[32'h0040_0004] = 32'h0000_1002;
    walk("R8", 32'hFFF0_1FFF, 0, 0, 32'h0000_1FFF, 4'h0, 2,
         32'h0010_3FFC, 32'h0040_0004, 0, 0);
    stall_mode = 0;
  endtask

  task automatic t_base_change;
    stall_mode = 1;
    mem[32'h0010_0000] = 32'h0050_0001;
    mem[32'h0050_0000] = 32'h7777_7012;
    mem[32'h0080_0000] = 32'h0000_0000;
    walk("R10", 32'h0000_0000, 0, 0, 32'h7777_7000, 4'h1, 2,
         32'h0010_0000, 32'h0050_0000, 1, 32'h0080_0000);
    stall_mode = 0;
    walk("R10", 32'h0000_0000, 1, 0, 32'h0, 4'h0, 1, 32'h0080_0000, 32'h0, 0, 0);
  endtask

  initial begin
    rst_n = 0; base_wr_en = 0; base_wr_data = 0;
    req_valid = 0; req_iova = 0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    set_base(32'h0010_0000);
    t_success();
    t_dir_codes();
    t_leaf_fault();
    t_stall_edge();
    t_base_change();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule